// File: doc/BRIEF.md
# Two-Master Address Bus Arbiter with CPU Parking

This block decides who owns the local processor address bus: the CPU or the internal snoop engine that carries PCI-to-memory traffic. When nobody asks for the bus, the CPU holds the grant ("parked"). A parked CPU may start a transaction without asserting its request. Such a start counts as a granted request.

Fairness between the two masters comes from a one-bit token. The token names the master that was granted least recently. On simultaneous requests, that master wins. The token moves only when a tenure actually begins.

When the snooper wants the bus while the CPU holds it parked, the arbiter first removes the CPU grant. It then watches a short window for a late CPU transfer start. If no start arrives, the snooper is granted. If a start does arrive, the CPU keeps that tenure, and the snooper follows after the CPU's address acknowledge.

Top module: `bus_park_arbiter`

## Requirements
- R1: After reset, the CPU grant is asserted, the snooper grant is deasserted, and the token favours the CPU.
- R2: The CPU grant and the snooper grant are never high in the same cycle.
- R3: With only the CPU requesting and the bus parked, the CPU grant stays asserted.
- R4: With the bus parked and the CPU not winning, a snooper request drops the CPU grant on the next cycle. Both grants then stay low for WAIT_LEN cycles (default 1), and after that the snooper grant rises.
- R5: A CPU transfer start seen during the wait window gives that tenure to the CPU. The snooper grant stays low until the cycle after that tenure's address acknowledge.
- R6: When both masters request while the bus is parked, the least recently granted master wins.
- R7: A transfer start by the parked CPU, with or without a request, begins a CPU tenure and makes the snooper the least recently granted master.
- R8: A CPU grant that began a tenure holds until the CPU address acknowledge. A snooper grant holds until snooper tenure-done. Arbitration resumes on the following cycle with the bus parked.
- R9: Parking, or a CPU request that is granted but never starts a transfer, leaves the token unchanged.
- R10: With no requests and no tenure in progress, the CPU grant is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU asks for the address bus |
| cpu_ts | input | 1 | CPU transfer start (begins an address tenure) |
| cpu_aack | input | 1 | Address acknowledge ending the CPU tenure |
| snp_req | input | 1 | Snoop engine asks for the address bus |
| snp_done | input | 1 | Snoop engine tenure finished |
| cpu_gnt | output | 1 | Address bus granted to the CPU (also parking) |
| snp_gnt | output | 1 | Address bus granted to the snoop engine |

## Verification
The bench tracks the token through a sequence of tenures, so it can tell which master should win each simultaneous request. A design whose token lags, never moves, or moves on mere parking would give such a request to the wrong master. It also starts a CPU transfer inside the wait window. A design that ignored that late start would raise the snooper grant while the CPU tenure is still open. The grant-free gap before the snooper grant, and the holding of each grant until its tenure end, are checked cycle by cycle. A design that skipped the window, or released a grant early, would show a grant change one cycle off the expected one.

// File: rtl/bus_park_arbiter_pkg.sv
// Shared types for the two-master address bus arbiter.
package bus_park_arbiter_pkg;

    // Master identity, used for the least-recently-granted token.
    typedef enum logic {
        MST_CPU = 1'b0,
        MST_SNP = 1'b1
    } master_e;

    // Arbiter control states.
    typedef enum logic [2:0] {
        ST_PARK     = 3'd0,  // CPU granted, no tenure open, arbitrating
        ST_CPU_TEN  = 3'd1,  // CPU tenure open, waiting for address ack
        ST_WINDOW   = 3'd2,  // CPU grant dropped, watching for a late start
        ST_CPU_LATE = 3'd3,  // late CPU tenure open, no grant driven
        ST_SNP_TEN  = 3'd4   // snooper tenure open
    } arb_state_e;

endpackage

// File: rtl/bus_park_token.sv
// Least-recently-granted token.
// Holds which master was granted least recently. It moves only on a
// tenure-start pulse from the controller. Assumes the two pulses are
// never raised together.
module bus_park_token
    import bus_park_arbiter_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cpu_began,   // CPU tenure began this cycle
    input  logic    snp_began,   // snooper tenure began this cycle
    output master_e lrg          // least recently granted master
);

    // Token register: after reset the CPU is favoured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lrg <= MST_CPU;
        end else if (cpu_began) begin
            lrg <= MST_SNP;
        end else if (snp_began) begin
            lrg <= MST_CPU;
        end
    end

    // R7: at most one tenure may begin in any cycle.
    p_single_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_began, snp_began}))
        else $error("p_single_start_r7");

    // R9: when no tenure begins, the token keeps its value.
    p_token_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_began && !snp_began) |=> $stable(lrg))
        else $error("p_token_still_r9");

endmodule

// File: rtl/bus_park_ctrl.sv
// Arbitration controller.
// Parks the bus on the CPU and treats a parked transfer start as a
// granted request. It hands the bus to the snooper through a grant-free
// window of WAIT_LEN cycles, and holds each grant until its tenure ends.
// Grants come straight from registers. Assumes cpu_aack arrives no
// earlier than the cycle after cpu_ts.
module bus_park_ctrl
    import bus_park_arbiter_pkg::*;
#(
    parameter int WAIT_LEN = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cpu_req,
    input  logic    cpu_ts,
    input  logic    cpu_aack,
    input  logic    snp_req,
    input  logic    snp_done,
    input  master_e lrg,
    output logic    cpu_began,
    output logic    snp_began,
    output logic    cpu_gnt,
    output logic    snp_gnt
);

    localparam int CW = (WAIT_LEN > 1) ? $clog2(WAIT_LEN) : 1;
    localparam logic [CW-1:0] WIN_LAST = CW'(WAIT_LEN - 1);

    arb_state_e    st_q, st_d;
    logic [CW-1:0] win_q, win_d;
    logic          cpu_wins;

    // CPU keeps a parked bus when it requests and the token favours it.
    assign cpu_wins = cpu_req && (lrg == MST_CPU);

    // Next-state selection and tenure-start pulses.
    always_comb begin
        st_d      = st_q;
        win_d     = win_q;
        cpu_began = 1'b0;
        snp_began = 1'b0;
        unique case (st_q)
            ST_PARK: begin
                if (cpu_ts) begin
                    st_d      = ST_CPU_TEN;
                    cpu_began = 1'b1;
                end else if (snp_req && !cpu_wins) begin
                    st_d  = ST_WINDOW;
                    win_d = '0;
                end
            end
            ST_CPU_TEN: begin
                if (cpu_aack) st_d = ST_PARK;
            end
            ST_WINDOW: begin
                if (cpu_ts) begin
                    st_d      = ST_CPU_LATE;
                    cpu_began = 1'b1;
                end else if (win_q == WIN_LAST) begin
                    if (snp_req) begin
                        st_d      = ST_SNP_TEN;
                        snp_began = 1'b1;
                    end else begin
                        st_d = ST_PARK;
                    end
                end else begin
                    win_d = win_q + 1'b1;
                end
            end
            ST_CPU_LATE: begin
                if (cpu_aack) begin
                    if (snp_req) begin
                        st_d      = ST_SNP_TEN;
                        snp_began = 1'b1;
                    end else begin
                        st_d = ST_PARK;
                    end
                end
            end
            ST_SNP_TEN: begin
                if (snp_done) st_d = ST_PARK;
            end
            default: st_d = ST_PARK;
        endcase
    end

    // State, window counter and registered grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_PARK;
            win_q   <= '0;
            cpu_gnt <= 1'b1;
            snp_gnt <= 1'b0;
        end else begin
            st_q    <= st_d;
            win_q   <= win_d;
            cpu_gnt <= (st_d == ST_PARK) || (st_d == ST_CPU_TEN);
            snp_gnt <= (st_d == ST_SNP_TEN);
        end
    end

    // R2: grants are mutually exclusive.
    p_grant_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt && snp_gnt))
        else $error("p_grant_excl_r2");

    // R4: the snooper grant rises only after a cycle with no CPU grant.
    p_snp_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snp_gnt) |-> $past(!cpu_gnt))
        else $error("p_snp_gap_r4");

    // R5: a late CPU start inside the window keeps the snooper waiting.
    p_late_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WINDOW && cpu_ts) |=> !snp_gnt)
        else $error("p_late_start_r5");

    // R8: the snooper grant holds until tenure-done.
    p_snp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_gnt && !snp_done) |=> snp_gnt)
        else $error("p_snp_hold_r8");

    // R8: an open CPU tenure keeps the CPU grant until the acknowledge.
    p_cpu_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CPU_TEN && !cpu_aack) |=> cpu_gnt)
        else $error("p_cpu_hold_r8");

endmodule

// File: rtl/bus_park_arbiter.sv
// Two-master address bus arbiter with CPU parking.
// Top level: joins the arbitration controller to the least-recently-
// granted token. The grant outputs are registered.
module bus_park_arbiter
    import bus_park_arbiter_pkg::*;
#(
    parameter int WAIT_LEN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_ts,
    input  logic cpu_aack,
    input  logic snp_req,
    input  logic snp_done,
    output logic cpu_gnt,
    output logic snp_gnt
);

    master_e lrg;
    logic    cpu_began;
    logic    snp_began;

    bus_park_ctrl #(.WAIT_LEN(WAIT_LEN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_ts    (cpu_ts),
        .cpu_aack  (cpu_aack),
        .snp_req   (snp_req),
        .snp_done  (snp_done),
        .lrg       (lrg),
        .cpu_began (cpu_began),
        .snp_began (snp_began),
        .cpu_gnt   (cpu_gnt),
        .snp_gnt   (snp_gnt)
    );

    bus_park_token u_token (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_began (cpu_began),
        .snp_began (snp_began),
        .lrg       (lrg)
    );

endmodule

// File: tb/bus_park_arbiter_tb.sv
// Scoreboard bench: the driver pushes expected grants, and the monitor
// pops and compares them one clock later.
module bus_park_arbiter_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  cpu;
        logic  snp;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_ts = 1'b0, cpu_aack = 1'b0;
    logic snp_req = 1'b0, snp_done = 1'b0;
    logic cpu_gnt, snp_gnt;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_park_arbiter #(.WAIT_LEN(1)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_ts   (cpu_ts),
        .cpu_aack (cpu_aack),
        .snp_req  (snp_req),
        .snp_done (snp_done),
        .cpu_gnt  (cpu_gnt),
        .snp_gnt  (snp_gnt)
    );

    // Drive one cycle of inputs and push the grants expected after the edge.
    task automatic step(input logic cr, input logic ts, input logic aa,
                        input logic sr, input logic sd,
                        input logic ec, input logic es, input string rq);
        exp_t e;
        @(negedge clk);
        cpu_req  = cr;
        cpu_ts   = ts;
        cpu_aack = aa;
        snp_req  = sr;
        snp_done = sd;
        e.cpu = ec;
        e.snp = es;
        e.req = rq;
        sb_q.push_back(e);
    endtask

    // Monitor: compare the grants just after each edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (cpu_gnt !== e.cpu || snp_gnt !== e.snp) begin
                n_fail++;
                $display("FAIL %s: cpu_gnt/snp_gnt = %b%b expected %b%b",
                         e.req, cpu_gnt, snp_gnt, e.cpu, e.snp);
            end
            n_chk++;
            if (cpu_gnt === 1'b1 && snp_gnt === 1'b1) begin
                n_fail++;
                $display("FAIL R2: grants = 11 expected not both high");
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 / R10: reset state, bus parked on the CPU.
        step(0,0,0,0,0, 1,0, "R1");
        step(0,0,0,0,0, 1,0, "R10");
        // R3: CPU-only request keeps the grant.
        step(1,0,0,0,0, 1,0, "R3");
        // R1/R6: token favours the CPU after reset, so the CPU wins both requests.
        step(1,0,0,1,0, 1,0, "R6");
        // R7: CPU starts; the snooper now becomes least recently granted.
        step(1,1,0,0,0, 1,0, "R7");
        // R8: the CPU tenure holds until the acknowledge.
        step(0,0,0,1,0, 1,0, "R8");
        step(0,0,1,0,0, 1,0, "R8");
        // R6: both request, token favours the snooper -> window, then grant.
        step(1,0,0,1,0, 0,0, "R6");
        step(1,0,0,1,0, 0,1, "R4");
        // R8: the snooper holds until done.
        step(1,0,0,1,0, 0,1, "R8");
        step(1,0,0,1,1, 1,0, "R8");
        // R6: the token now favours the CPU, which keeps the grant with both requesting.
        step(1,0,0,1,0, 1,0, "R6");
        // R9: CPU granted but never starts; token must not move.
        step(1,0,0,0,0, 1,0, "R9");
        step(0,0,0,0,0, 1,0, "R9");
        step(1,0,0,1,0, 1,0, "R9");
        // R7: a parked start without a request counts as a granted request.
        step(0,1,0,0,0, 1,0, "R7");
        step(0,0,1,0,0, 1,0, "R8");
        step(1,0,0,1,0, 0,0, "R7");
        step(0,0,0,1,0, 0,1, "R4");
        step(0,0,0,0,1, 1,0, "R8");
        // R4: a lone snooper request sees the gap and then its grant.
        step(0,0,0,1,0, 0,0, "R4");
        step(0,0,0,1,0, 0,1, "R4");
        step(0,0,0,0,1, 1,0, "R10");
        // R5: a late CPU start inside the window.
        step(0,0,0,1,0, 0,0, "R5");
        step(0,1,0,1,0, 0,0, "R5");
        step(0,0,0,1,0, 0,0, "R5");
        step(0,0,1,1,0, 0,1, "R5");
        step(0,0,0,0,1, 1,0, "R8");
        step(0,0,0,0,0, 1,0, "R10");
        @(negedge clk);
        cpu_req = 0; cpu_ts = 0; cpu_aack = 0; snp_req = 0; snp_done = 0;
        repeat (2) @(posedge clk);
        #2;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule